// File: doc/BRIEF.md
# In-Array Bitwise AND/OR Command Sequencer

This block sits on the memory-controller side of a DRAM subarray. It accepts one request that names an operation (AND or OR), two source rows and a destination row. It then emits the row commands that make the subarray compute the destination as the bitwise combination of the two sources, entirely inside the array. The work is done by four in-array row copies. Each copy opens a source row, opens a target row while the source is still open, and then closes the bank. The first two copies move the sources into compute rows. The third copy loads a constant row into the third compute row, and the choice of constant selects AND or OR. The last copy opens all three compute rows at once and copies the majority result into the destination.

A per-request mode picks the timing. Conservative mode waits a full activate window between the two opens of each copy. Aggressive mode issues the second open one cycle after the first. Activate and precharge windows are parameters counted in clock cycles. A one-cycle `done` pulse marks the end of the command stream. To combine more than two rows, the requester chains requests. Each later request names the previous destination as a source and writes the same destination again, so partial results accumulate there.

Top module: `bulk_logic_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `cmd_valid` and `done` are 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle of the `done` pulse. While it is 0, requests are ignored and produce no commands.
- R3: The command code on `cmd_kind` is 0 for a single-row open of `cmd_row`, 1 for a triple open of the three compute rows (with `cmd_row` equal to the first compute row), and 2 for a precharge (with `cmd_row` 0). With ROWS = 2^ROW_W, the compute rows are ROWS-5, ROWS-4 and ROWS-3. The all-zero row is ROWS-2 and the all-one row is ROWS-1.
- R4: A request produces exactly 12 commands, in this order: open A, open D1, precharge; open B, open D2, precharge; open the constant row, open D3, precharge; triple open, open C, precharge.
- R5: Op input 0 (AND) copies the all-zero row into D3. Op input 1 (OR) copies the all-one row into D3.
- R6: In conservative mode (mode 0), each copy spans 2*T_ACT+T_PRE cycles. The second open follows the first by T_ACT cycles, and the precharge follows the second open by T_ACT cycles. The next copy's first open follows the precharge by T_PRE cycles.
- R7: In aggressive mode (mode 1), the second open follows the first by 1 cycle, and the precharge follows the first open by T_ACT cycles. Each copy spans T_ACT+T_PRE cycles.
- R8: `done` is a one-cycle pulse. It appears 4 copy spans after the cycle in which the first command appears, which is 68 cycles (conservative) or 40 cycles (aggressive) with the default parameters.
- R9: Each precharge comes at least T_ACT cycles after the open that started its copy. Each copy's first open comes at least T_PRE cycles after the previous precharge.
- R10: `req_ready` is 1 in the cycle of `done`. A chained request that reuses the previous destination as a source is accepted at the edge that ends that cycle, and its first command appears one cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_op | input | 1 | 0 = AND, 1 = OR |
| req_mode | input | 1 | 0 = conservative, 1 = aggressive overlap |
| req_src_a | input | ROW_W | First source row |
| req_src_b | input | ROW_W | Second source row |
| req_dst | input | ROW_W | Destination row |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 0 open, 1 triple open, 2 precharge |
| cmd_row | output | ROW_W | Row addressed by the command |
| done | output | 1 | Command stream for the request finished |

## Verification
The hardest case to reach is the one where a request arrives in the very cycle that `done` is high. In that case, the tail of one command stream and the head of the next must meet with no lost or extra cycle. The stimulus reaches it by chaining a three-row OR. The driver waits only on `req_ready`, and the second request names the first request's destination as a source, so the hand-off lands exactly in the `done` cycle. Requests that arrive while the block is busy are also hard to see from outside. The bench holds `req_valid` high with unrelated fields in the middle of a sequence, and the scoreboard then requires that no command outside the expected trace appears.

// File: rtl/bulk_logic_seq.sv
module bulk_logic_seq #(
  parameter int ROW_W = 10,
  parameter int T_ACT = 7,
  parameter int T_PRE = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic             req_mode,
  input  logic [ROW_W-1:0] req_src_a,
  input  logic [ROW_W-1:0] req_src_b,
  input  logic [ROW_W-1:0] req_dst,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic             done
);
  localparam int ROWS = 1 << ROW_W;
  localparam logic [ROW_W-1:0] ROW_D1   = ROW_W'(ROWS - 5);
  localparam logic [ROW_W-1:0] ROW_D2   = ROW_W'(ROWS - 4);
  localparam logic [ROW_W-1:0] ROW_D3   = ROW_W'(ROWS - 3);
  localparam logic [ROW_W-1:0] ROW_ZERO = ROW_W'(ROWS - 2);
  localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(ROWS - 1);
  localparam logic [1:0] K_ACT = 2'd0, K_TRI = 2'd1, K_PRE = 2'd2;
  localparam logic [1:0] PH_OPEN1 = 2'd0, PH_OPEN2 = 2'd1, PH_CLOSED = 2'd2;
  localparam logic [CNT_W-1:0] CONS_GAP = CNT_W'(T_ACT - 1);
  localparam logic [CNT_W-1:0] AGGR_GAP2 = CNT_W'(T_ACT - 2);
  localparam logic [CNT_W-1:0] PRE_GAP = CNT_W'(T_PRE - 1);

  logic             busy, op_q, mode_q;
  logic [1:0]       step, phase;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] a_q, b_q, c_q;
  logic [ROW_W-1:0] dst_row, nxt_src;
  logic [1:0]       nxt_step;
  logic [CNT_W-1:0] gap1, gap2;

  assign req_ready = !busy;
  assign nxt_step  = step + 2'd1;
  assign gap1 = mode_q ? '0 : CONS_GAP;
  assign gap2 = mode_q ? AGGR_GAP2 : CONS_GAP;

  always_comb begin
    case (step)
      2'd0:    dst_row = ROW_D1;
      2'd1:    dst_row = ROW_D2;
      2'd2:    dst_row = ROW_D3;
      default: dst_row = c_q;
    endcase
    case (nxt_step)
      2'd1:    nxt_src = b_q;
      2'd2:    nxt_src = op_q ? ROW_ONE : ROW_ZERO;
      default: nxt_src = ROW_D1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op_q      <= 1'b0;
      mode_q    <= 1'b0;
      step      <= '0;
      phase     <= PH_OPEN1;
      cnt       <= '0;
      a_q       <= '0;
      b_q       <= '0;
      c_q       <= '0;
      cmd_valid <= 1'b0;
      cmd_kind  <= K_ACT;
      cmd_row   <= '0;
      done      <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy      <= 1'b1;
          op_q      <= req_op;
          mode_q    <= req_mode;
          a_q       <= req_src_a;
          b_q       <= req_src_b;
          c_q       <= req_dst;
          step      <= 2'd0;
          phase     <= PH_OPEN1;
          cnt       <= req_mode ? '0 : CONS_GAP;
          cmd_valid <= 1'b1;
          cmd_kind  <= K_ACT;
          cmd_row   <= req_src_a;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (phase)
          PH_OPEN1: begin
            cmd_valid <= 1'b1;
            cmd_kind  <= K_ACT;
            cmd_row   <= dst_row;
            phase     <= PH_OPEN2;
            cnt       <= gap2;
          end
          PH_OPEN2: begin
            cmd_valid <= 1'b1;
            cmd_kind  <= K_PRE;
            cmd_row   <= '0;
            phase     <= PH_CLOSED;
            cnt       <= PRE_GAP;
          end
          default: begin
            if (step == 2'd3) begin
              done <= 1'b1;
              busy <= 1'b0;
            end else begin
              step      <= nxt_step;
              phase     <= PH_OPEN1;
              cnt       <= gap1;
              cmd_valid <= 1'b1;
              cmd_kind  <= (nxt_step == 2'd3) ? K_TRI : K_ACT;
              cmd_row   <= nxt_src;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bulk_logic_seq_chk.sv
module bulk_logic_seq_chk #(
  parameter int ROW_W = 10,
  parameter int T_ACT = 7,
  parameter int T_PRE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [ROW_W-1:0] cmd_row,
  input logic             done
);
  logic       opened;
  logic [7:0] since_open, since_pre;
  wire is_pre  = cmd_valid && cmd_kind == 2'd2;
  wire is_open = cmd_valid && cmd_kind != 2'd2 && !opened;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opened     <= 1'b0;
      since_open <= 8'hff;
      since_pre  <= 8'hff;
    end else begin
      if (is_open) opened <= 1'b1;
      else if (is_pre) opened <= 1'b0;
      since_open <= is_open ? 8'd1 : (since_open == 8'hff ? since_open : since_open + 8'd1);
      since_pre  <= is_pre  ? 8'd1 : (since_pre  == 8'hff ? since_pre  : since_pre  + 8'd1);
    end
  end

  a_r9_pre_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> since_open >= 8'(T_ACT));
  a_r9_open_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_open |-> since_pre >= 8'(T_PRE));
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r2_cmd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
  a_r3_pre_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> cmd_row == '0);
  a_r3_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_kind != 2'd3);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind bulk_logic_seq bulk_logic_seq_chk #(.ROW_W(ROW_W), .T_ACT(T_ACT), .T_PRE(T_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row), .done(done));

// File: tb/test_bulk_logic_seq.sv
module test_bulk_logic_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 10;
  localparam int T_ACT = 7;
  localparam int T_PRE = 3;
  localparam int ROWS = 1 << ROW_W;
  localparam int D1 = ROWS - 5, D2 = ROWS - 4, D3 = ROWS - 3, RZ = ROWS - 2, RO = ROWS - 1;

  typedef struct { int cyc; int kind; int row; string tag; } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0, req_mode = 0;
  logic [ROW_W-1:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
  logic req_ready, cmd_valid, done;
  logic [1:0] cmd_kind;
  logic [ROW_W-1:0] cmd_row;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit finished = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bulk_logic_seq #(.ROW_W(ROW_W), .T_ACT(T_ACT), .T_PRE(T_PRE)) i_bulk_logic_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mode(req_mode), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_dst(req_dst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row),
    .done(done));

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(int c, int k, int r, string tag);
    item_t it;
    it.cyc = c; it.kind = k; it.row = r; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic send(bit op, bit mode, int a, int b, int c);
    int t0, g1, g2, per;
    string tm;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    t0 = cyc + 1;
    g1 = mode ? 1 : T_ACT;
    g2 = mode ? T_ACT - 1 : T_ACT;
    per = g1 + g2 + T_PRE;
    tm = mode ? "R7" : "R6";
    for (int s = 0; s < 4; s++) begin
      int src, dst, base;
      base = t0 + s * per;
      src = (s == 0) ? a : (s == 1) ? b : (s == 2) ? (op ? RO : RZ) : D1;
      dst = (s == 0) ? D1 : (s == 1) ? D2 : (s == 2) ? D3 : c;
      push(base, (s == 3) ? 1 : 0, src, (s == 2) ? "R5" : "R4");
      push(base + g1, 0, dst, tm);
      push(base + g1 + g2, 2, 0, "R3");
    end
    push(t0 + 4 * per, 3, 0, "R8");
    req_valid = 1; req_op = op; req_mode = mode;
    req_src_a = ROW_W'(a); req_src_b = ROW_W'(b); req_dst = ROW_W'(c);
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R2 ready low after accept", req_ready, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && (cmd_valid || done)) begin
      if (q.size() == 0) begin
        check(0, "R2 unexpected output", cmd_valid ? int'(cmd_kind) : 3, -1);
      end else begin
        item_t e;
        e = q.pop_front();
        if (done) begin
          check(e.kind == 3 && e.cyc == cyc && !cmd_valid, {e.tag, " done time"}, cyc, e.cyc);
          check(req_ready == 1, "R10 ready in done cycle", req_ready, 1);
        end else begin
          check(e.kind == int'(cmd_kind), {e.tag, " kind"}, cmd_kind, e.kind);
          check(e.row == int'(cmd_row), {e.tag, " row"}, cmd_row, e.row);
          check(e.cyc == cyc, {e.tag, " time"}, cyc, e.cyc);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);
    check(cmd_valid == 0, "R1 no command after reset", cmd_valid, 0);
    check(done == 0, "R1 no done after reset", done, 0);

    send(0, 0, 17, 42, 300);
    // R2: requests during a busy sequence must be ignored
    req_valid = 1; req_op = 1; req_mode = 1;
    req_src_a = 10'd5; req_src_b = 10'd6; req_dst = 10'd7;
    repeat (6) @(negedge clk);
    req_valid = 0;

    send(1, 0, 100, 200, 400);
    send(0, 1, 1, 2, 3);
    send(1, 1, 900, 901, 902);
    // R10: three-row OR chained through the destination
    send(1, 0, 11, 12, 500);
    send(1, 0, 500, 13, 500);
    send(1, 1, 21, 22, 600);
    send(1, 1, 600, 23, 600);

    while (q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(req_ready == 1, "R2 idle at end", req_ready, 1);
    finish_run();
  end
endmodule